// File: doc/BRIEF.md
# Flash Program Status and Masking Engine

This block is a synthesizable behavioural model of a small NOR flash word array while it runs embedded program and erase operations. A host issues commands (program one word, erase the whole array, suspend or resume an erase, report a buffered-write abort, reset, and abort-reset). The host also issues reads. While an operation is active, every read returns a status byte instead of array data. A program can only clear bits, so the stored word becomes the old word AND the requested word. An erase sets every bit of every word back to one.

Each operation runs a pulse counter. An operation finishes when its counter reaches a pulse count set by a parameter. If the count passes a limit, the operation has failed. The `force_tmo` test input pushes the running count past the limit at once, so failure paths can be reached on demand. A failed operation holds its status until a reset command. An aborted buffered write holds its status until the dedicated abort-reset command.

Top module: `flash_status_engine`

## Requirements
- R1: After reset every word reads as all ones and `rd_data` is zero. Outside an active operation, a read returns the addressed word on `rd_data` one cycle after `rd_en`. The modes that are not active are read mode and erase-suspended read.
- R2: During an active operation a read returns this status byte, zero-extended: bit 7 is the inverse of bit 7 of the operation's target data (all ones for an erase), bits 6 and 2 are the toggle value, bit 5 is the timeout flag, bit 3 is 1 only while an erase is running, bit 1 is the abort flag, and all other bits are 0. The active modes are program, erase, program during suspend, timed out, and aborted.
- R3: The toggle value is 0 on the first status read after an operation starts. It inverts after every status read and does not change on cycles without a read.
- R4: A program stores old AND new data. Any 1 requested over a stored 0 is dropped without setting bit 5.
- R5: An erase leaves every word at all ones once ERASE_PULSES pulses have run. The erase status (bit 3 = 1) is returned on each of those pulse cycles.
- R6: A program accepted at clock edge e0 returns status on reads taken at edges e1 to e(PROG_PULSES). A read at edge e(PROG_PULSES+1) returns array data.
- R7: When the running pulse count passes PULSE_LIMIT (`force_tmo` causes this), the operation stops with bit 5 set and the array unchanged. The block then holds this state until a reset command, which returns it to read mode.
- R8: An erase can be suspended (command 4). In the suspended state array reads and programs are allowed. A program that times out there returns, on reset, to the suspended state, not to read mode. Resume (command 5) then completes the erase.
- R9: A buffered-write abort (command 6) makes status reads show bit 1 = 1. A reset command does not clear it. Only the abort-reset command (command 7) returns the block to read mode.
- R10: A command that is not valid in the current mode is ignored. Command codes: 0 none, 1 program, 2 erase, 3 reset, 4 suspend, 5 resume, 6 buffer abort, 7 abort reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R10) |
| cmd_addr | input | clog2(WORDS) | Program target word |
| cmd_data | input | DATA_W | Program data or aborted buffer data |
| force_tmo | input | 1 | Test input: push the running pulse count past the limit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | clog2(WORDS) | Read word address |
| rd_data | output | DATA_W | Registered read result: array word or status byte |

## Verification
The bench builds the block with DATA_W=8, WORDS=4, PROG_PULSES=3, ERASE_PULSES=6 and PULSE_LIMIT=10. Short operations make exact cycle-by-cycle read sequences practical across a whole program or erase. They also make it affordable to sweep 256 pairs of old and new data values, each pair on a freshly erased word, so every bit sees both the masked and the cleared outcome. The timeout input then reaches the failure, suspend and abort paths within a few cycles each.

// File: rtl/flash_stat_pkg.sv
// Shared command codes, mode encoding and status bit positions for the
// flash status engine. Assumes a status byte of eight bits.
package flash_stat_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_RESET     = 3'd3,
        OP_SUSPEND   = 3'd4,
        OP_RESUME    = 3'd5,
        OP_BUF_ABORT = 3'd6,
        OP_ABORT_CLR = 3'd7
    } fop_e;

    typedef enum logic [2:0] {
        MD_READ      = 3'd0,
        MD_PROG      = 3'd1,
        MD_ERASE     = 3'd2,
        MD_SUSP_RD   = 3'd3,
        MD_SUSP_PROG = 3'd4,
        MD_FAIL      = 3'd5,
        MD_ABORT     = 3'd6
    } fmode_e;

    localparam int ST_POLL  = 7;
    localparam int ST_TGL_A = 6;
    localparam int ST_TMO   = 5;
    localparam int ST_ERS   = 3;
    localparam int ST_TGL_B = 2;
    localparam int ST_ABT   = 1;

    // True when reads must return the status byte rather than array data.
    function automatic logic mode_active(input fmode_e m);
        return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SUSP_PROG) ||
               (m == MD_FAIL) || (m == MD_ABORT);
    endfunction

endpackage

// File: rtl/fpe_pulse_counter.sv
// Pulse counter for one embedded operation. It counts once per cycle while
// run is high and reports done on the pulse that reaches need. Once the count
// passes LIMIT it saturates and reports over. force_over jumps straight past
// the limit. Assumes need <= LIMIT+1 for a normal finish.
module fpe_pulse_counter #(
    parameter int LIMIT = 64,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          force_over,
    input  logic [CW-1:0] need,
    output logic          done,
    output logic          over
);
    localparam logic [CW-1:0] OVER_VAL = CW'(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign over = (cnt_q >= OVER_VAL);
    assign done = run && !force_over && !over && ((cnt_q + CW'(1)) == need);

    // Advance, clear, force or saturate the pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            if (force_over || over) cnt_q <= OVER_VAL;
            else                    cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/fpe_word_array.sv
// Word storage for the flash model. A program ANDs the new data into one
// word, so bits can only be cleared. An erase sets every word to all ones.
// The read port is combinational. Assumes WORDS is a power of two.
module fpe_word_array #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 16,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [AW-1:0]     prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_all,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem_q [WORDS];

    assign rd_word = mem_q[rd_addr];

    // Apply reset, erase or masked program to the stored words.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_all) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (prog_en) begin
            mem_q[prog_addr] <= mem_q[prog_addr] & prog_data;
        end
    end
endmodule

// File: rtl/fpe_status_fmt.sv
// Builds the eight-bit status byte from the current mode, the toggle bit
// and bit 7 of the operation's target data. Purely combinational.
module fpe_status_fmt
    import flash_stat_pkg::*;
(
    input  fmode_e      mode,
    input  logic        tgl,
    input  logic        tgt_msb,
    output logic [7:0]  status
);
    // Place each indicator in its bit position.
    always_comb begin
        status           = '0;
        status[ST_POLL]  = ~tgt_msb;
        status[ST_TGL_A] = tgl;
        status[ST_TGL_B] = tgl;
        status[ST_TMO]   = (mode == MD_FAIL);
        status[ST_ERS]   = (mode == MD_ERASE);
        status[ST_ABT]   = (mode == MD_ABORT);
    end
endmodule

// File: rtl/flash_status_engine.sv
// Top of the flash status engine. A mode machine accepts commands, runs one
// pulse counter for programs and one for erases (so a suspended erase keeps
// its count while a program runs), and returns either array data or the
// status byte on registered reads. Assumes DATA_W >= 8 and PROG_PULSES,
// ERASE_PULSES >= 1.
module flash_status_engine
    import flash_stat_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int WORDS        = 8,
    parameter int PROG_PULSES  = 8,
    parameter int ERASE_PULSES = 32,
    parameter int PULSE_LIMIT  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [$clog2(WORDS)-1:0] cmd_addr,
    input  logic [DATA_W-1:0]        cmd_data,
    input  logic                     force_tmo,
    input  logic                     rd_en,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int AW    = $clog2(WORDS);
    localparam int MAXA  = (PULSE_LIMIT + 1 > PROG_PULSES) ? PULSE_LIMIT + 1 : PROG_PULSES;
    localparam int MAXV  = (MAXA > ERASE_PULSES) ? MAXA : ERASE_PULSES;
    localparam int CW    = $clog2(MAXV + 1) + 1;
    localparam int NCNT  = 2;     // index 0: program, index 1: erase

    fmode_e            mode_q;
    logic              ret_susp_q;
    logic              tgl_q;
    logic [DATA_W-1:0] tgt_data_q;
    logic [AW-1:0]     tgt_addr_q;

    fop_e              op;
    logic              is_act;
    logic [NCNT-1:0]   c_clear, c_run, c_done, c_over;
    logic [DATA_W-1:0] arr_word;
    logic [7:0]        status;

    assign op     = fop_e'(cmd_op);
    assign is_act = mode_active(mode_q);

    // Decide when each pulse counter starts and runs.
    always_comb begin
        c_clear[0] = cmd_valid && (op == OP_PROG) &&
                     ((mode_q == MD_READ) || (mode_q == MD_SUSP_RD));
        c_run[0]   = (mode_q == MD_PROG) || (mode_q == MD_SUSP_PROG);
        c_clear[1] = cmd_valid && (op == OP_ERASE) && (mode_q == MD_READ);
        c_run[1]   = (mode_q == MD_ERASE);
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        fpe_pulse_counter #(
            .LIMIT (PULSE_LIMIT),
            .CW    (CW)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (c_clear[g]),
            .run        (c_run[g]),
            .force_over (force_tmo),
            .need       ((g == 0) ? CW'(PROG_PULSES) : CW'(ERASE_PULSES)),
            .done       (c_done[g]),
            .over       (c_over[g])
        );
    end

    fpe_word_array #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (c_done[0]),
        .prog_addr (tgt_addr_q),
        .prog_data (tgt_data_q),
        .erase_all (c_done[1]),
        .rd_addr   (rd_addr),
        .rd_word   (arr_word)
    );

    fpe_status_fmt u_fmt (
        .mode    (mode_q),
        .tgl     (tgl_q),
        .tgt_msb (tgt_data_q[7]),
        .status  (status)
    );

    // Mode machine: accept commands valid for the mode, finish or fail ops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MD_READ;
            ret_susp_q <= 1'b0;
            tgl_q      <= 1'b0;
            tgt_data_q <= '1;
            tgt_addr_q <= '0;
        end else begin
            if (rd_en && is_act) tgl_q <= ~tgl_q;
            unique case (mode_q)
                MD_READ: if (cmd_valid) begin
                    if (op == OP_PROG) begin
                        mode_q     <= MD_PROG;
                        tgt_data_q <= cmd_data;
                        tgt_addr_q <= cmd_addr;
                        tgl_q      <= 1'b0;
                    end else if (op == OP_ERASE) begin
                        mode_q     <= MD_ERASE;
                        tgt_data_q <= '1;
                        tgl_q      <= 1'b0;
                    end else if (op == OP_BUF_ABORT) begin
                        mode_q     <= MD_ABORT;
                        tgt_data_q <= cmd_data;
                        tgl_q      <= 1'b0;
                    end
                end
                MD_PROG: begin
                    if (c_over[0]) begin
                        mode_q     <= MD_FAIL;
                        ret_susp_q <= 1'b0;
                    end else if (c_done[0]) begin
                        mode_q     <= MD_READ;
                    end
                end
                MD_ERASE: begin
                    if (c_over[1]) begin
                        mode_q     <= MD_FAIL;
                        ret_susp_q <= 1'b0;
                    end else if (c_done[1]) begin
                        mode_q     <= MD_READ;
                    end else if (cmd_valid && op == OP_SUSPEND) begin
                        mode_q     <= MD_SUSP_RD;
                    end
                end
                MD_SUSP_RD: if (cmd_valid) begin
                    if (op == OP_PROG) begin
                        mode_q     <= MD_SUSP_PROG;
                        tgt_data_q <= cmd_data;
                        tgt_addr_q <= cmd_addr;
                        tgl_q      <= 1'b0;
                    end else if (op == OP_RESUME) begin
                        mode_q     <= MD_ERASE;
                        tgt_data_q <= '1;
                        tgl_q      <= 1'b0;
                    end
                end
                MD_SUSP_PROG: begin
                    if (c_over[0]) begin
                        mode_q     <= MD_FAIL;
                        ret_susp_q <= 1'b1;
                    end else if (c_done[0]) begin
                        mode_q     <= MD_SUSP_RD;
                    end
                end
                MD_FAIL: if (cmd_valid && op == OP_RESET) begin
                    mode_q <= ret_susp_q ? MD_SUSP_RD : MD_READ;
                end
                MD_ABORT: if (cmd_valid && op == OP_ABORT_CLR) begin
                    mode_q <= MD_READ;
                end
                default: mode_q <= MD_READ;
            endcase
        end
    end

    // Registered read port: status byte while active, array word otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_en)  rd_data <= is_act ? DATA_W'(status) : arr_word;
    end
endmodule

// File: rtl/fpe_status_chk.sv
// Checker for the flash status engine, attached by bind. It watches reads,
// the mode and the array read word.
module fpe_status_chk
    import flash_stat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [2:0]        mode,
    input logic [DATA_W-1:0] arr_word,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op
);
    logic act;
    assign act = mode_active(fmode_e'(mode));

    // R1
    array_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !act) |=> (rd_data == $past(arr_word)));

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && act && $past(rd_en && act && rst_n)) |=>
        (rd_data[6] != $past(rd_data[6]) && rd_data[2] == rd_data[6]));

    // R7
    timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == 3'(MD_FAIL)) |=> rd_data[5]);

    // R9
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == 3'(MD_ABORT)) |=> (rd_data[1] && !rd_data[5]));

    // R9
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'(MD_ABORT) && cmd_valid && cmd_op == 3'(OP_RESET)) |=>
        (mode == 3'(MD_ABORT)));
endmodule

bind flash_status_engine fpe_status_chk #(.DATA_W(DATA_W)) u_status_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .mode      (mode_q),
    .arr_word  (arr_word),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op)
);

// File: tb/tb_flash_status_engine.sv
module tb_flash_status_engine;
    localparam int DW = 8, NW = 4, PP = 3, EP = 6, LIM = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_addr = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       force_tmo = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;

    int checks = 0, failures = 0;
    logic [7:0] v;

    always #2 clk = ~clk;

    flash_status_engine #(.DATA_W(DW), .WORDS(NW), .PROG_PULSES(PP),
        .ERASE_PULSES(EP), .PULSE_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .force_tmo(force_tmo),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [7:0] st(input logic d7, input logic t,
        input logic tmo, input logic ers, input logic abt);
        return {~d7, t, tmo, 1'b0, ers, t, abt, 1'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    // All tasks are entered and left at a falling edge.
    task automatic cmd(input logic [2:0] op, input logic [1:0] a, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] val);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tmo();
        force_tmo = 1'b1;
        @(negedge clk);
        force_tmo = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] oldv, newv, exp, st0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 reset rd_data", rd_data, 8'h00);
        for (int a = 0; a < NW; a++) begin
            rd(2'(a), v); check("R1 reset word", v, 8'hFF);
        end

        // R6 / R3 exact program timing: status at e1..e3, array at e4
        cmd(3'd1, 2'd0, 8'h3C);
        rd(2'd0, v); check("R6 R3 read e1", v, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        rd(2'd0, v); check("R6 R3 read e2", v, st(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        rd(2'd0, v); check("R6 R3 read e3", v, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        rd(2'd0, v); check("R6 read e4 array", v, 8'h3C);

        // R5 exact erase timing: six erase statuses then all ones
        cmd(3'd2, 2'd0, 8'h00);
        for (int k = 0; k < EP; k++) begin
            rd(2'd0, v); check("R5 R2 erase status", v, st(1'b1, 1'(k % 2), 1'b0, 1'b1, 1'b0));
        end
        rd(2'd0, v); check("R5 erased word", v, 8'hFF);

        // R3 toggle holds across cycles without reads
        cmd(3'd2, 2'd0, 8'h00);
        rd(2'd0, v); check("R3 first read", v, st(1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
        idle(1);
        rd(2'd0, v); check("R3 no flip on idle", v, st(1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
        idle(6);

        // R4 / R1 / R2 sweep: old and new data pairs on an erased word
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [1:0] a;
                a = 2'((i + j) % NW);
                oldv = 8'(i * 17) ^ 8'h0F;
                newv = 8'(j * 29) ^ 8'h5A;
                exp  = oldv & newv;
                cmd(3'd2, 2'd0, 8'h00); idle(EP + 2);
                rd(a, v); check("R5 sweep erase", v, 8'hFF);
                cmd(3'd1, a, oldv); idle(PP + 2);
                cmd(3'd1, a, newv);
                rd(a, v); check("R4 R2 no timeout on masked bits", v,
                                st(newv[7], 1'b0, 1'b0, 1'b0, 1'b0));
                idle(PP + 1);
                rd(a, v); check("R4 old AND new", v, exp);
                rd(a + 2'd1, v); check("R1 neighbour untouched", v, 8'hFF);
            end
        end

        // R7 program timeout, ignored program, reset back to read mode
        cmd(3'd2, 2'd0, 8'h00); idle(EP + 2);
        cmd(3'd1, 2'd0, 8'h0F);
        push_tmo(); idle(1);
        rd(2'd0, v); check("R7 timeout status", v, st(1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        rd(2'd0, v); check("R7 R3 timeout toggles", v, st(1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
        cmd(3'd1, 2'd1, 8'h00);
        rd(2'd0, v); check("R10 program ignored in timeout", v, st(1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        cmd(3'd3, 2'd0, 8'h00);
        rd(2'd0, v); check("R7 array unchanged after reset", v, 8'hFF);
        rd(2'd1, v); check("R10 ignored program left word", v, 8'hFF);

        // R7 erase timeout keeps data
        cmd(3'd1, 2'd1, 8'h33); idle(PP + 2);
        cmd(3'd2, 2'd0, 8'h00);
        push_tmo(); idle(1);
        rd(2'd0, v); check("R7 erase timeout status", v, st(1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        cmd(3'd3, 2'd0, 8'h00);
        rd(2'd1, v); check("R7 erase timeout keeps data", v, 8'h33);

        // R10 program during erase is ignored
        cmd(3'd2, 2'd0, 8'h00);
        cmd(3'd1, 2'd2, 8'h00);
        idle(EP + 2);
        rd(2'd2, v); check("R10 program ignored during erase", v, 8'hFF);
        cmd(3'd1, 2'd1, 8'h33); idle(PP + 2);

        // R8 suspend, program, timeout in suspend, reset, resume
        cmd(3'd2, 2'd0, 8'h00);
        cmd(3'd4, 2'd0, 8'h00);
        rd(2'd1, v); check("R8 suspend read array", v, 8'h33);
        cmd(3'd1, 2'd2, 8'h5A); idle(PP + 2);
        rd(2'd2, v); check("R8 program in suspend", v, 8'h5A);
        cmd(3'd1, 2'd2, 8'h0F);
        push_tmo(); idle(1);
        rd(2'd2, v); check("R8 suspend program timeout", v, st(1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        cmd(3'd3, 2'd0, 8'h00);
        rd(2'd2, v); check("R8 back to suspend read", v, 8'h5A);
        cmd(3'd5, 2'd0, 8'h00);
        idle(EP + 2);
        rd(2'd1, v); check("R8 resumed erase done w1", v, 8'hFF);
        rd(2'd2, v); check("R8 resumed erase done w2", v, 8'hFF);

        // R9 buffer abort: reset ignored, abort reset restores read
        cmd(3'd6, 2'd0, 8'h12);
        rd(2'd0, v); st0 = v;
        check("R9 abort status", st0, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        rd(2'd0, v); check("R9 R3 abort toggles", v, st(1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
        cmd(3'd3, 2'd0, 8'h00);
        rd(2'd0, v); check("R9 reset ignored", v, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        cmd(3'd7, 2'd0, 8'h00);
        rd(2'd0, v); check("R9 abort reset restores read", v, 8'hFF);

        // R10 resume in read mode is ignored
        cmd(3'd1, 2'd3, 8'hA5); idle(PP + 2);
        cmd(3'd5, 2'd0, 8'h00); idle(EP + 2);
        rd(2'd3, v); check("R10 resume ignored in read", v, 8'hA5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule